// File: doc/BRIEF.md
# Relay Coil Matrix Command Sequencer

This block turns the relay fields of a decoded command into a timed drive of a latching-relay coil matrix with 7 rows and 8 columns. A command decoder upstream gives it three things in order: a strobe saying the command type is relay, a strobe with the direction bit, and a strobe with the six-bit row/column select. A parity verdict follows the select. The block models the coil-energy bank with handshakes. It asks for charge as soon as the command type is known. It fires only after every field has arrived and the bank reports ready.

If parity is good and the row is in range, the block drives exactly one row switch and one column switch for a programmable number of cycles. The polarity output carries the latched direction. If parity fails, or the row code points past the last row, the block drops the charge request and gives a one-cycle discharge pulse. No switch is closed in that case.

A register of telltale bits, one per matrix crossing, records the direction last fired at each relay so that telemetry can confirm execution. A relay command that arrives while a pulse is still being driven is refused. The refusal shows as a one-cycle reject pulse, and the pulse in progress is not disturbed.

Top module: `relay_matrix_exec`

## Requirements
- R1: After reset, every output is 0, including all telltale bits.
- R2: A `type_vld` strobe with `type_relay`=1, taken while idle, raises `charge_en` on the next cycle. `charge_en` stays high until the command fires or aborts. A `type_vld` strobe with `type_relay`=0 is ignored.
- R3: The `dir_bit` taken with `dir_vld` (1 = ON, 0 = OFF) appears on `pulse_pol` for the whole fire pulse. `pulse_pol` is 0 when no pulse is being driven.
- R4: The select code taken with `sel_vld` carries the row in bits [5:3] and the column in bits [2:0]. While firing, `row_en` has only bit `row` set and `col_en` has only bit `col` set. Otherwise both are all zero.
- R5: A `par_vld` strobe with `par_ok`=0 aborts the command. `charge_en` falls on the next cycle, `bleed` pulses for exactly that one cycle, and no switch is driven.
- R6: A row code of 7 aborts the command in the same way as a parity failure, even when parity is good.
- R7: The fire pulse lasts `fire_len` cycles, sampled when firing starts, with 0 treated as 1. After the pulse all enables return to 0 and the block is idle.
- R8: `busy` is high exactly while a pulse is being driven. A relay-type strobe during that time produces a one-cycle `reject` pulse on the next cycle. It changes neither the pulse in progress nor the next idle state.
- R9: When firing starts, telltale bit row*8+col takes the fired direction. No other telltale bit changes, and no bit changes at any other time.
- R10: After a good verdict, firing waits with `charge_en` held high until `bank_ready` is sampled high. The first fire cycle follows that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| type_vld | input | 1 | Command type decoded this cycle |
| type_relay | input | 1 | 1 when the decoded type is relay |
| dir_vld | input | 1 | Direction bit valid |
| dir_bit | input | 1 | Direction, 1 = ON, 0 = OFF |
| sel_vld | input | 1 | Row/column select valid |
| sel_code | input | 6 | Row in [5:3], column in [2:0] |
| par_vld | input | 1 | Parity verdict valid |
| par_ok | input | 1 | 1 when parity passed |
| bank_ready | input | 1 | Coil energy bank charged |
| fire_len | input | 8 | Fire pulse length in cycles |
| charge_en | output | 1 | Request to charge the energy bank |
| bleed | output | 1 | One-cycle discharge pulse on abort |
| row_en | output | 7 | One-hot row switch drive |
| col_en | output | 8 | One-hot column switch drive |
| pulse_pol | output | 1 | Coil pulse polarity during firing |
| busy | output | 1 | Fire pulse in progress |
| reject | output | 1 | Relay command refused while busy |
| telltale | output | 56 | Last fired direction per relay, bit row*8+col |

## Verification
The bench targets row code 7 with good parity. A design that checked only parity would close a nonexistent row switch and write a telltale bit past the last row. A fire length of zero is exercised because a naive down-counter would wrap around and hold the coils for 256 cycles. A design that skipped the ready wait would fire before `bank_ready` rises, so that case is driven with the bank held low for several cycles. A relay strobe during a pulse checks that the pulse neither restarts nor ends early. The extreme crossings (0,0) and (6,7) and an OFF pulse over a bit that was set ON catch an off-by-one telltale index, or a telltale that only ever sets bits.

// File: rtl/relay_matrix_exec.sv
module relay_matrix_exec #(
  parameter int ROWS = 7,
  parameter int COLS = 8,
  parameter int FW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 type_vld,
  input  logic                 type_relay,
  input  logic                 dir_vld,
  input  logic                 dir_bit,
  input  logic                 sel_vld,
  input  logic [5:0]           sel_code,
  input  logic                 par_vld,
  input  logic                 par_ok,
  input  logic                 bank_ready,
  input  logic [FW-1:0]        fire_len,
  output logic                 charge_en,
  output logic                 bleed,
  output logic [ROWS-1:0]      row_en,
  output logic [COLS-1:0]      col_en,
  output logic                 pulse_pol,
  output logic                 busy,
  output logic                 reject,
  output logic [ROWS*COLS-1:0] telltale
);
  typedef enum logic [2:0] {S_IDLE, S_DIR, S_SEL, S_PAR, S_ARM, S_FIRE} st_t;

  st_t           st;
  logic          pol_q;
  logic [2:0]    row_q, col_q;
  logic [FW-1:0] cnt;

  wire relay_hit = type_vld & type_relay;
  wire row_ok    = {1'b0, row_q} < 4'(ROWS);
  wire col_ok    = {1'b0, col_q} < 4'(COLS);
  wire start     = (st == S_ARM) & bank_ready;

  assign charge_en = (st == S_DIR) | (st == S_SEL) | (st == S_PAR) | (st == S_ARM);
  assign busy      = (st == S_FIRE);
  assign pulse_pol = busy & pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pol_q  <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      cnt    <= '0;
      bleed  <= 1'b0;
      reject <= 1'b0;
    end else begin
      bleed  <= 1'b0;
      reject <= 1'b0;
      case (st)
        S_IDLE: if (relay_hit) st <= S_DIR;
        S_DIR: if (dir_vld) begin
          pol_q <= dir_bit;
          st    <= S_SEL;
        end
        S_SEL: if (sel_vld) begin
          row_q <= sel_code[5:3];
          col_q <= sel_code[2:0];
          st    <= S_PAR;
        end
        S_PAR: if (par_vld) begin
          if (par_ok && row_ok && col_ok) st <= S_ARM;
          else begin
            bleed <= 1'b1;
            st    <= S_IDLE;
          end
        end
        S_ARM: if (bank_ready) begin
          cnt <= (fire_len == '0) ? FW'(1) : fire_len;
          st  <= S_FIRE;
        end
        S_FIRE: begin
          if (relay_hit) reject <= 1'b1;
          if (cnt == FW'(1)) st <= S_IDLE;
          else cnt <= cnt - FW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_en[r] = busy & (row_q == 3'(r));
    for (genvar c = 0; c < COLS; c++) begin : g_cell
      always_ff @(posedge clk) begin
        if (!rst_n) telltale[r*COLS+c] <= 1'b0;
        else if (start && row_q == 3'(r) && col_q == 3'(c)) telltale[r*COLS+c] <= pol_q;
      end
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_en[c] = busy & (col_q == 3'(c));
  end
endmodule

module relay_matrix_exec_chk #(
  parameter int ROWS = 7,
  parameter int COLS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 type_vld,
  input logic                 type_relay,
  input logic                 charge_en,
  input logic                 bleed,
  input logic [ROWS-1:0]      row_en,
  input logic [COLS-1:0]      col_en,
  input logic                 pulse_pol,
  input logic                 busy,
  input logic                 reject,
  input logic [ROWS*COLS-1:0] telltale
);
  AST_CHARGE_EARLY: assert property (@(posedge clk) disable iff (!rst_n) (type_vld && type_relay && !charge_en && !busy) |=> charge_en); // R2
  AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n) busy |-> ($countones(row_en) == 1 && $countones(col_en) == 1)); // R4
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (row_en == '0 && col_en == '0 && !pulse_pol)); // R3
  AST_ABORT_SAFE: assert property (@(posedge clk) disable iff (!rst_n) bleed |-> (!busy && !charge_en)); // R5
  AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && type_vld && type_relay) |=> reject); // R8
  AST_TELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$rose(busy) |-> $stable(telltale)); // R9
endmodule

bind relay_matrix_exec relay_matrix_exec_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .type_vld(type_vld), .type_relay(type_relay),
  .charge_en(charge_en), .bleed(bleed), .row_en(row_en), .col_en(col_en),
  .pulse_pol(pulse_pol), .busy(busy), .reject(reject), .telltale(telltale)
);

// File: tb/tb_relay_matrix_exec.sv
module tb_relay_matrix_exec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic type_vld = 0, type_relay = 0, dir_vld = 0, dir_bit = 0, sel_vld = 0, par_vld = 0, par_ok = 0, bank_ready = 0;
  logic [5:0] sel_code = '0;
  logic [7:0] fire_len = 8'd1;
  logic charge_en, bleed, pulse_pol, busy, reject;
  logic [6:0] row_en;
  logic [7:0] col_en;
  logic [55:0] telltale;

  always #5 clk = ~clk;

  relay_matrix_exec dut (
    .clk(clk), .rst_n(rst_n), .type_vld(type_vld), .type_relay(type_relay),
    .dir_vld(dir_vld), .dir_bit(dir_bit), .sel_vld(sel_vld), .sel_code(sel_code),
    .par_vld(par_vld), .par_ok(par_ok), .bank_ready(bank_ready), .fire_len(fire_len),
    .charge_en(charge_en), .bleed(bleed), .row_en(row_en), .col_en(col_en),
    .pulse_pol(pulse_pol), .busy(busy), .reject(reject), .telltale(telltale)
  );

  int checks = 0, fails = 0, cycles = 0;
  string scen = "R1";

  // behavioural reference: phase 0 idle, 1 want dir, 2 want select, 3 want verdict, 4 wait bank, 5 firing
  int m_ph = 0, m_row = 0, m_col = 0, m_left = 0;
  bit m_pol = 0, m_bleed = 0, m_rej = 0;
  bit [55:0] m_tell = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s/%s act=%h exp=%h at cycle %0d", scen, tag, act, exp, cycles);
    end
  endtask

  task automatic model_step();
    m_bleed = 0;
    m_rej = 0;
    if (!rst_n) begin
      m_ph = 0; m_tell = '0;
      return;
    end
    if (m_ph == 0) begin
      if (type_vld && type_relay) m_ph = 1;
    end else if (m_ph == 1) begin
      if (dir_vld) begin m_pol = dir_bit; m_ph = 2; end
    end else if (m_ph == 2) begin
      if (sel_vld) begin m_row = int'(sel_code[5:3]); m_col = int'(sel_code[2:0]); m_ph = 3; end
    end else if (m_ph == 3) begin
      if (par_vld) begin
        if (par_ok && m_row < 7) m_ph = 4;
        else begin m_bleed = 1; m_ph = 0; end
      end
    end else if (m_ph == 4) begin
      if (bank_ready) begin
        m_left = (fire_len == 0) ? 1 : int'(fire_len);
        m_tell[m_row*8+m_col] = m_pol;
        m_ph = 5;
      end
    end else begin
      if (type_vld && type_relay) m_rej = 1;
      m_left--;
      if (m_left == 0) m_ph = 0;
    end
  endtask

  task automatic compare();
    bit f = (m_ph == 5);
    chk("R2 charge_en", 64'(charge_en), 64'(m_ph >= 1 && m_ph <= 4));
    chk("R5 bleed", 64'(bleed), 64'(m_bleed));
    chk("R4 row_en", 64'(row_en), f ? 64'(1) << m_row : 64'(0));
    chk("R4 col_en", 64'(col_en), f ? 64'(1) << m_col : 64'(0));
    chk("R3 pulse_pol", 64'(pulse_pol), 64'(f & m_pol));
    chk("R8 busy", 64'(busy), 64'(f));
    chk("R8 reject", 64'(reject), 64'(m_rej));
    chk("R9 telltale", 64'(telltale), 64'(m_tell));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    cycles++;
    @(negedge clk);
    compare();
    type_vld = 0; type_relay = 0; dir_vld = 0; sel_vld = 0; par_vld = 0;
  endtask

  task automatic relay_cmd(bit d, int r, int c, bit ok, int gap);
    type_vld = 1; type_relay = 1; cyc();
    repeat (gap) cyc();
    dir_vld = 1; dir_bit = d; cyc();
    sel_vld = 1; sel_code = {3'(r), 3'(c)}; cyc();
    repeat (gap) cyc();
    par_vld = 1; par_ok = ok; cyc();
  endtask

  initial begin
    @(negedge clk);
    cyc(); cyc();
    scen = "R1";
    chk("R1 outputs", {charge_en, bleed, row_en, col_en, pulse_pol, busy, reject}, 64'(0));
    chk("R1 telltale", 64'(telltale), 64'(0));
    rst_n = 1;
    cyc();

    scen = "R2";
    type_vld = 1; type_relay = 0; cyc();
    chk("R2 non-relay ignored", 64'(charge_en), 64'(0));
    cyc();

    scen = "R4";
    bank_ready = 1; fire_len = 8'd3;
    relay_cmd(1, 2, 5, 1, 1);
    repeat (5) cyc();
    chk("R9 bit 21 set", 64'(telltale[21]), 64'(1));

    scen = "R10";
    bank_ready = 0; fire_len = 8'd2;
    relay_cmd(1, 0, 0, 1, 0);
    repeat (4) cyc();
    chk("R10 still charging", 64'(charge_en), 64'(1));
    chk("R10 not firing", 64'(busy), 64'(0));
    bank_ready = 1; cyc();
    chk("R10 fires after ready", 64'(busy), 64'(1));
    repeat (3) cyc();

    scen = "R5";
    relay_cmd(1, 3, 3, 0, 0);
    chk("R5 bleed pulse", 64'(bleed), 64'(1));
    chk("R5 no drive", 64'(row_en), 64'(0));
    cyc();
    chk("R5 bleed one cycle", 64'(bleed), 64'(0));

    scen = "R6";
    relay_cmd(1, 7, 2, 1, 0);
    chk("R6 row7 abort", 64'(bleed), 64'(1));
    repeat (3) cyc();
    chk("R6 no fire", 64'(busy), 64'(0));

    scen = "R7";
    fire_len = 8'd0;
    relay_cmd(1, 6, 7, 1, 0);
    cyc();
    chk("R7 len0 one cycle", 64'(busy), 64'(1));
    cyc();
    chk("R7 len0 ended", 64'(busy), 64'(0));
    chk("R9 bit 55 set", 64'(telltale[55]), 64'(1));

    scen = "R8";
    fire_len = 8'd6;
    relay_cmd(0, 2, 5, 1, 0);
    cyc(); cyc();
    type_vld = 1; type_relay = 1; cyc();
    chk("R8 reject pulse", 64'(reject), 64'(1));
    chk("R8 still busy", 64'(busy), 64'(1));
    repeat (6) cyc();
    chk("R8 idle after", 64'(charge_en | busy), 64'(0));
    chk("R9 bit 21 cleared", 64'(telltale[21]), 64'(0));

    scen = "R3";
    fire_len = 8'd4;
    for (int i = 0; i < 6; i++) begin
      relay_cmd(1'(i & 1), i, 7 - i, 1, i % 2);
      repeat (6) cyc();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule